// File: doc/BRIEF.md
# Registered Command Buffer with Parity

This block sits between a memory controller and the loads on a memory module. On every rising clock edge it captures a command and address word and drives it to several identical output copies, so one register stage feeds two groups of loads. By default the word is 28 bits wide and there are two copies.

The buffer also checks the controller's even parity. The low 22 bits of the word and the controller's parity bit are XORed together, and a result of one pulls the active-low error output low. The check is pipelined over two register stages to keep the XOR tree short. The error therefore appears one clock after the copies show the word that carried it.

Two active-low rank selects gate the block. When neither rank is selected, the copies keep their values and that cycle's word is not checked. A synchronous active-low reset clears every copy to zero and clears the error.

Top module: `cmdbuf_reg`

## Requirements
- R1: While `rst_n` is low at a rising edge, every output copy becomes zero after that edge and `par_err_n` is high after it. `rst_n` is sampled synchronously.
- R2: If at least one bit of `rank_cs_n` is 0 at a rising edge, every copy takes `cmd_in` at that edge.
- R3: All copies in `cmd_out` are equal on every cycle. Copy k occupies bits [k*28+27 : k*28].
- R4: If both bits of `rank_cs_n` are 1 at a rising edge, no copy changes at that edge.
- R5: The check uses even parity. For a word captured with at least one select active, an error exists when the XOR of `cmd_in[21:0]` and `cmd_par` is 1.
- R6: `par_err_n` is low for exactly the one cycle that follows the edge after the one capturing an erroneous word. In all other cycles it is high.
- R7: A word presented while both selects are high is never checked, so `par_err_n` stays high for its slot.
- R8: Bits `cmd_in[27:22]` are registered but play no part in the parity result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_in | input | 28 | Command and address word |
| cmd_par | input | 1 | Even parity bit from the controller, covers cmd_in[21:0] |
| rank_cs_n | input | 2 | Rank selects, active low; all high freezes the outputs |
| cmd_out | output | 56 | Output copies of the registered word, copy 0 in the low bits |
| par_err_n | output | 1 | Parity error flag, active low |

## Verification
The in-RTL assertions check four things on every cycle:
- the copies agree;
- a deselected edge leaves them unchanged;
- reset clears the copies and the flag;
- a low error flag always traces back two edges to a cycle that had a select active and was out of reset.

Only the bench's reference model can show the rest. That covers whether the error flag is low for the right words and in the right cycle, whether the upper six bits are really left out of the check, and whether a reset in the middle of the pipeline drops an error that was still pending.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;
    localparam int unsigned CMD_W_DEF  = 28;
    localparam int unsigned CHK_W_DEF  = 22;
    localparam int unsigned CS_W_DEF   = 2;
    localparam int unsigned COPIES_DEF = 2;
    localparam int unsigned GRP_W_DEF  = 6;

    function automatic int unsigned ceil_div(input int unsigned a, input int unsigned b);
        return (a + b - 1) / b;
    endfunction
endpackage

// File: rtl/cmdbuf_fanout.sv
module cmdbuf_fanout #(
    parameter int unsigned CMD_W  = cmdbuf_pkg::CMD_W_DEF,
    parameter int unsigned COPIES = cmdbuf_pkg::COPIES_DEF
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic [CMD_W-1:0]              word,
    output logic [COPIES-1:0][CMD_W-1:0]  copies
);
    typedef struct packed {
        logic [COPIES-1:0][CMD_W-1:0] copy;
    } fan_state_t;

    fan_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < COPIES; k++) begin
            if (!rst_n) begin
                st_d.copy[k] = '0;
            end else if (load) begin
                st_d.copy[k] = word;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign copies = st_q.copy;

    generate
        for (genvar k = 1; k < COPIES; k++) begin : g_same
            // R3
            copies_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.copy[k] == st_q.copy[0]);
        end
    endgenerate

    // R4
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && rst_n) |=> $stable(st_q.copy));

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (st_q.copy == '0));
endmodule

// File: rtl/cmdbuf_parity.sv
module cmdbuf_parity #(
    parameter int unsigned CHK_W = cmdbuf_pkg::CHK_W_DEF,
    parameter int unsigned GRP_W = cmdbuf_pkg::GRP_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             check_en,
    input  logic [CHK_W-1:0] chk_bits,
    input  logic             par_bit,
    output logic             err_n
);
    localparam int unsigned NGRP  = cmdbuf_pkg::ceil_div(CHK_W, GRP_W);
    localparam int unsigned PAD_W = NGRP * GRP_W;

    typedef struct packed {
        logic [NGRP-1:0] part;
        logic            par;
        logic            vld;
        logic            err_n;
    } par_state_t;

    par_state_t      st_d, st_q;
    logic [PAD_W-1:0] padded;
    logic [NGRP-1:0]  part_now;

    assign padded = PAD_W'(chk_bits);

    generate
        for (genvar g = 0; g < NGRP; g++) begin : g_grp
            assign part_now[g] = ^padded[g*GRP_W +: GRP_W];
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.part  = '0;
            st_d.par   = 1'b0;
            st_d.vld   = 1'b0;
            st_d.err_n = 1'b1;
        end else begin
            st_d.part  = part_now;
            st_d.par   = par_bit;
            st_d.vld   = check_en;
            st_d.err_n = ~(st_q.vld & (^st_q.part ^ st_q.par));
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign err_n = st_q.err_n;

    // R7
    err_traces_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.err_n |-> ($past(check_en, 2) && $past(rst_n, 2)));

    // R1
    reset_err_idle_chk: assert property (@(posedge clk)
        !rst_n |=> st_q.err_n);
endmodule

// File: rtl/cmdbuf_reg.sv
module cmdbuf_reg #(
    parameter int unsigned CMD_W  = cmdbuf_pkg::CMD_W_DEF,
    parameter int unsigned CHK_W  = cmdbuf_pkg::CHK_W_DEF,
    parameter int unsigned CS_W   = cmdbuf_pkg::CS_W_DEF,
    parameter int unsigned COPIES = cmdbuf_pkg::COPIES_DEF,
    parameter int unsigned GRP_W  = cmdbuf_pkg::GRP_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CMD_W-1:0]        cmd_in,
    input  logic                    cmd_par,
    input  logic [CS_W-1:0]         rank_cs_n,
    output logic [COPIES*CMD_W-1:0] cmd_out,
    output logic                    par_err_n
);
    logic                         sel_any;
    logic [COPIES-1:0][CMD_W-1:0] copies;

    assign sel_any = ~&rank_cs_n;

    cmdbuf_fanout #(.CMD_W(CMD_W), .COPIES(COPIES)) fan_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (sel_any),
        .word   (cmd_in),
        .copies (copies)
    );

    cmdbuf_parity #(.CHK_W(CHK_W), .GRP_W(GRP_W)) par_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .check_en (sel_any),
        .chk_bits (cmd_in[CHK_W-1:0]),
        .par_bit  (cmd_par),
        .err_n    (par_err_n)
    );

    assign cmd_out = copies;

    // R4
    ports_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&rank_cs_n) |=> $stable(cmd_out));
endmodule

// File: tb/cmdbuf_reg_tb.sv
module cmdbuf_reg_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [27:0] cmd_in = '0;
    logic        cmd_par = 1'b0;
    logic [1:0]  rank_cs_n = 2'b11;
    logic [55:0] cmd_out;
    logic        par_err_n;

    int n_run  = 0;
    int n_fail = 0;
    string out_tag = "R2";
    string err_tag = "R5 R6";

    // reference state
    logic [27:0] m_out = '0;
    logic        m_pend_v = 1'b0;
    logic        m_pend_bad = 1'b0;
    logic        m_err_n = 1'b1;

    always #10 clk = ~clk;

    cmdbuf_reg dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_in(cmd_in), .cmd_par(cmd_par),
        .rank_cs_n(rank_cs_n), .cmd_out(cmd_out), .par_err_n(par_err_n)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_out = '0; m_pend_v = 1'b0; m_pend_bad = 1'b0; m_err_n = 1'b1;
        end else begin
            m_err_n    = !(m_pend_v && m_pend_bad);
            m_pend_v   = (rank_cs_n != 2'b11);
            m_pend_bad = (^cmd_in[21:0]) ^ cmd_par;
            if (rank_cs_n != 2'b11) m_out = cmd_in;
        end
        #1;
        check({out_tag, " copy0"}, 64'(cmd_out[27:0]), 64'(m_out));
        check("R3 copy1", 64'(cmd_out[55:28]), 64'(cmd_out[27:0]));
        check(err_tag, 64'(par_err_n), 64'(m_err_n));
    end

    task automatic drive(input logic [27:0] w, input bit bad, input logic [1:0] cs, input logic rst);
        @(negedge clk);
        cmd_in    = w;
        cmd_par   = (^w[21:0]) ^ bad;
        rank_cs_n = cs;
        rst_n     = rst;
    endtask

    function automatic logic [1:0] pick_cs();
        int r = $urandom_range(2);
        return (r == 0) ? 2'b00 : (r == 1) ? 2'b01 : 2'b10;
    endfunction

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        out_tag = "R1"; err_tag = "R1";
        for (int i = 0; i < 3; i++) drive(28'(i * 32'h0123457), 1'b1, 2'b00, 1'b0);
        // R1 explicit reset state
        check("R1 reset copies", 64'(cmd_out), 64'd0);
        check("R1 reset err", 64'(par_err_n), 64'd1);

        out_tag = "R2"; err_tag = "R5 R6 good";
        for (int i = 0; i < 40; i++) drive(28'($urandom), 1'b0, pick_cs(), 1'b1);

        err_tag = "R5 R6 flipped";
        for (int i = 0; i < 60; i++) drive(28'($urandom), bit'($urandom_range(1)), pick_cs(), 1'b1);

        out_tag = "R4"; err_tag = "R7";
        for (int i = 0; i < 20; i++) drive(28'($urandom), 1'b1, 2'b11, 1'b1);
        for (int i = 0; i < 30; i++)
            drive(28'($urandom), bit'($urandom_range(1)),
                  ($urandom_range(1) == 1) ? 2'b11 : pick_cs(), 1'b1);

        out_tag = "R2"; err_tag = "R8";
        for (int i = 0; i < 30; i++) begin
            logic [27:0] w = {6'($urandom), 22'h2A5A5A};
            drive(w, 1'b0, pick_cs(), 1'b1);
        end

        out_tag = "R1"; err_tag = "R1 R6";
        drive(28'h0FFFFFF, 1'b1, 2'b00, 1'b1);
        drive(28'h0000001, 1'b1, 2'b01, 1'b0);
        drive(28'h0000003, 1'b1, 2'b10, 1'b1);
        for (int i = 0; i < 20; i++) drive(28'($urandom), bit'($urandom_range(1)), pick_cs(), 1'b1);
        drive(28'h0, 1'b0, 2'b11, 1'b1);
        drive(28'h0, 1'b0, 2'b11, 1'b1);
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule